// File: doc/BRIEF.md
# Maskable Interrupt Controller with Selectable Pin Behaviour

This block gathers single-cycle event strobes from the surrounding terminal logic into a sticky status register. It drives one active-low interrupt pin. A host-written mask register enables each source on its own. A configuration register selects two things: how the pin behaves, and whether masked-off sources still record their status.

The pin has three behaviours. In pulse mode it goes low for a fixed number of cycles for each new enabled event. In the first level mode it stays low until software issues a clear. In the second level mode a status read clears both the status and the pin. Under the standard update policy, only enabled sources set status bits. Under the enhanced policy, every source sets its status bit. In both policies, only enabled sources can drive the pin. Source 0 carries the time tag rollover event.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the status register is 0, the mask register is 0, the pin mode is pulse (code 00), the update policy is standard (enh_o = 0), and irq_no is high.
- R2: A mask write or configuration write takes effect at the next clock edge and can be read back on mask_o, pin_mode_o and enh_o. Pin mode codes: 00 pulse, 01 level until software clear, 10 level cleared by status read, 11 behaves as 01.
- R3: Standard policy (enh_o = 0): status bit i is set at the clock edge after evt_i[i] is high only if mask bit i is 1. Masked events leave the status unchanged.
- R4: Enhanced policy (enh_o = 1): status bit i is set at the clock edge after evt_i[i] is high, whatever mask bit i holds.
- R5: Set status bits stay set until a software clear, or a status read in mode 10.
- R6: In modes 01, 10 and 11, irq_no is low exactly when some status bit has its mask bit at 1. Status bits whose mask bit is 0 never pull the pin low.
- R7: In mode 00, a cycle with an event on any enabled source makes irq_no low for exactly PULSE_LEN cycles, starting at the next edge. An enabled event during the window restarts it. Masked events give no pulse.
- R8: In mode 10, a cycle with stat_rd_i high clears every status bit at the next edge. Qualifying events in that same cycle are still recorded. In other modes a read clears nothing.
- R9: A cycle with sw_clr_i high clears all status bits at the next edge, which releases the level output. Qualifying events in the same cycle are kept.
- R10: evt_i[0] is the time tag rollover source and follows the same masking and status rules as every other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Single-cycle event strobes; bit 0 is the time tag rollover |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | NUM_SRC | Mask write data; 1 enables a source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Pin mode write data |
| cfg_enh_i | input | 1 | Update policy write data; 1 is enhanced |
| stat_rd_i | input | 1 | Status read strobe |
| sw_clr_i | input | 1 | Software clear command |
| mask_o | output | NUM_SRC | Mask register contents |
| pin_mode_o | output | 2 | Current pin mode |
| enh_o | output | 1 | Current update policy |
| stat_o | output | NUM_SRC | Status register contents |
| irq_no | output | 1 | Active-low interrupt pin |

## Verification
The bench puts an event in the same cycle as a status read or a software clear. A design that lets the clear win would lose that event, so the next read would show nothing. It sets status bits with masked sources under the enhanced policy. A design that wires the pin to raw status would then assert the pin for a disabled source. It retriggers a pulse mid-window and counts the low cycles exactly, which exposes off-by-one pulse lengths and windows that ignore a restart. It also issues reads in the non-auto level modes, where a design that clears on every read would drop bits it must keep.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    PIN_PULSE      = 2'b00,
    PIN_LEVEL_SW   = 2'b01,
    PIN_LEVEL_AUTO = 2'b10,
    PIN_LEVEL_ALT  = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic               cfg_enh_i,
  output logic [NUM_SRC-1:0] mask_o,
  output pin_mode_e          mode_o,
  output logic               enh_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
    end else if (mask_we_i) begin
      mask_o <= mask_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= PIN_PULSE;
      enh_o  <= 1'b0;
    end else if (cfg_we_i) begin
      mode_o <= pin_mode_e'(cfg_mode_i);
      enh_o  <= cfg_enh_i;
    end
  end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               enh_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] stat_o
);
  logic [NUM_SRC-1:0] qual;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    // enhanced policy bypasses the mask for status capture only
    assign qual[b] = evt_i[b] & (enh_i | mask_i[b]);
  end

  // same-cycle events survive a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
    end else begin
      stat_o <= (clr_i ? '0 : stat_o) | qual;
    end
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (trig_i) begin
      cnt_q <= CW'(PULSE_LEN);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic               cfg_enh_i,
  input  logic               stat_rd_i,
  input  logic               sw_clr_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [1:0]         pin_mode_o,
  output logic               enh_o,
  output logic [NUM_SRC-1:0] stat_o,
  output logic               irq_no
);
  pin_mode_e          mode;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] stat;
  logic               enh;
  logic               clr;
  logic               trig;
  logic               pulse_active;
  logic               level_active;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_mode_i   (cfg_mode_i),
    .cfg_enh_i    (cfg_enh_i),
    .mask_o       (mask),
    .mode_o       (mode),
    .enh_o        (enh)
  );

  // read-to-clear only in auto mode
  assign clr = sw_clr_i | (stat_rd_i & (mode == PIN_LEVEL_AUTO));

  irq_status #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .mask_i (mask),
    .enh_i  (enh),
    .clr_i  (clr),
    .stat_o (stat)
  );

  assign trig = (mode == PIN_PULSE) & (|(evt_i & mask));

  irq_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig),
    .active_o (pulse_active)
  );

  assign level_active = |(stat & mask);
  assign irq_no       = (mode == PIN_PULSE) ? ~pulse_active : ~level_active;

  assign mask_o     = mask;
  assign pin_mode_o = mode;
  assign enh_o      = enh;
  assign stat_o     = stat;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               stat_rd_i,
  input logic               sw_clr_i,
  input logic [NUM_SRC-1:0] mask_o,
  input logic [1:0]         pin_mode_o,
  input logic               enh_o,
  input logic [NUM_SRC-1:0] stat_o,
  input logic               irq_no
);
  p_std_no_masked_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_o |=> ((stat_o & ~$past(stat_o) & ~$past(mask_o)) == '0));

  p_enh_always_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enh_o |=> (($past(evt_i) & ~stat_o) == '0));

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_clr_i && !(stat_rd_i && pin_mode_o == 2'b10)) |=> (($past(stat_o) & ~stat_o) == '0));

  p_level_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_mode_o != 2'b00) |-> (irq_no == !(|(stat_o & mask_o))));

  p_pulse_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_mode_o == 2'b00 && |(evt_i & mask_o)) |=> (pin_mode_o != 2'b00 || !irq_no));

  p_auto_read_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && pin_mode_o == 2'b10) |=> ((stat_o & ~$past(evt_i)) == '0));

  p_sw_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_i |=> ((stat_o & ~$past(evt_i)) == '0));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .stat_rd_i  (stat_rd_i),
  .sw_clr_i   (sw_clr_i),
  .mask_o     (mask_o),
  .pin_mode_o (pin_mode_o),
  .enh_o      (enh_o),
  .stat_o     (stat_o),
  .irq_no     (irq_no)
);

// File: tb/evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_ctrl_test;
  localparam int N   = 8;
  localparam int PL  = 4;
  localparam int CLK = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         mask_we_i = 1'b0;
  logic [N-1:0] mask_wdata_i = '0;
  logic         cfg_we_i = 1'b0;
  logic [1:0]   cfg_mode_i = 2'b00;
  logic         cfg_enh_i = 1'b0;
  logic         stat_rd_i = 1'b0;
  logic         sw_clr_i = 1'b0;
  logic [N-1:0] mask_o;
  logic [1:0]   pin_mode_o;
  logic         enh_o;
  logic [N-1:0] stat_o;
  logic         irq_no;

  evt_irq_ctrl #(.NUM_SRC(N), .PULSE_LEN(PL)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i), .cfg_enh_i(cfg_enh_i),
    .stat_rd_i(stat_rd_i), .sw_clr_i(sw_clr_i),
    .mask_o(mask_o), .pin_mode_o(pin_mode_o), .enh_o(enh_o),
    .stat_o(stat_o), .irq_no(irq_no)
  );

  always #(CLK/2) clk_i = ~clk_i;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  logic [N-1:0] m_mask, m_stat;
  logic [1:0]   m_mode;
  logic         m_enh;
  int           m_left;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask = '0; m_stat = '0; m_mode = 2'b00; m_enh = 1'b0; m_left = 0;
    end else begin
      logic [N-1:0] cap;
      bit wipe, fire;
      cap  = m_enh ? evt_i : (evt_i & m_mask);
      wipe = sw_clr_i || (stat_rd_i && m_mode == 2'b10);
      fire = (m_mode == 2'b00) && ((evt_i & m_mask) != 0);
      if (wipe) m_stat = '0;
      m_stat = m_stat | cap;
      if (fire) m_left = PL;
      else if (m_left > 0) m_left = m_left - 1;
      if (mask_we_i) m_mask = mask_wdata_i;
      if (cfg_we_i) begin m_mode = cfg_mode_i; m_enh = cfg_enh_i; end
    end
  end

  function automatic logic exp_irq_n();
    if (m_mode == 2'b00) return (m_left == 0);
    return ((m_stat & m_mask) == 0);
  endfunction

  // per-cycle compare
  always @(negedge clk_i) begin
    if (rst_ni) begin
      n_cmp++;
      if (stat_o !== m_stat || irq_no !== exp_irq_n() || mask_o !== m_mask ||
          pin_mode_o !== m_mode || enh_o !== m_enh) begin
        n_bad++;
        $display("FAIL %s cycle compare: stat=%h irq_n=%b mask=%h mode=%b enh=%b exp stat=%h irq_n=%b mask=%h mode=%b enh=%b",
                 cur_req, stat_o, irq_no, mask_o, pin_mode_o, enh_o,
                 m_stat, exp_irq_n(), m_mask, m_mode, m_enh);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock: drive at current time, hold across the edge, then release
  task automatic step(input logic [N-1:0] ev = '0, input logic rd = 1'b0, input logic clr = 1'b0);
    evt_i = ev; stat_rd_i = rd; sw_clr_i = clr;
    @(posedge clk_i); #2;
    evt_i = '0; stat_rd_i = 1'b0; sw_clr_i = 1'b0;
  endtask

  task automatic wr_mask(input logic [N-1:0] m);
    mask_we_i = 1'b1; mask_wdata_i = m;
    @(posedge clk_i); #2;
    mask_we_i = 1'b0;
  endtask

  task automatic wr_cfg(input logic [1:0] md, input logic en);
    cfg_we_i = 1'b1; cfg_mode_i = md; cfg_enh_i = en;
    @(posedge clk_i); #2;
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK * 3 + 2);
    // R1 reset state
    chk("R1", "stat", stat_o, 0);
    chk("R1", "irq_n", irq_no, 1);
    chk("R1", "mask", mask_o, 0);
    chk("R1", "mode", pin_mode_o, 0);
    chk("R1", "enh", enh_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #2;

    cur_req = "R2";
    wr_mask(8'hA5);
    chk("R2", "mask readback", mask_o, 8'hA5);
    wr_cfg(2'b01, 1'b0);
    chk("R2", "mode readback", pin_mode_o, 2'b01);
    chk("R2", "enh readback", enh_o, 0);

    cur_req = "R3";
    step(8'h5A);
    chk("R3", "masked events ignored", stat_o, 8'h00);
    chk("R3", "pin idle after masked", irq_no, 1);
    step(8'hFF);
    chk("R3", "enabled events only", stat_o, 8'hA5);
    cur_req = "R6";
    chk("R6", "level pin low", irq_no, 0);
    cur_req = "R5";
    step(); step(); step(8'h00, 1'b1);
    chk("R5", "sticky over idle and read in mode 01", stat_o, 8'hA5);

    cur_req = "R9";
    step(8'h00, 1'b0, 1'b1);
    chk("R9", "sw clear status", stat_o, 8'h00);
    chk("R9", "sw clear pin", irq_no, 1);
    step(8'h04, 1'b0, 1'b1);
    chk("R9", "event kept through clear", stat_o, 8'h04);
    step(8'h00, 1'b0, 1'b1);

    cur_req = "R4";
    wr_cfg(2'b01, 1'b1);
    step(8'h02);
    chk("R4", "enhanced sets masked bit", stat_o, 8'h02);
    chk("R6", "masked status leaves pin high", irq_no, 1);
    cur_req = "R10";
    step(8'h01);
    chk("R10", "rollover status", stat_o, 8'h03);
    chk("R10", "rollover asserts pin", irq_no, 0);

    cur_req = "R8";
    wr_cfg(2'b10, 1'b1);
    step(8'h04, 1'b1);
    chk("R8", "read clears old, keeps same-cycle event", stat_o, 8'h04);
    chk("R8", "pin from kept event", irq_no, 0);
    step(8'h00, 1'b1);
    chk("R8", "second read clears", stat_o, 8'h00);
    chk("R8", "pin released", irq_no, 1);
    wr_cfg(2'b01, 1'b1);
    step(8'h01);
    step(8'h00, 1'b1);
    chk("R8", "read in mode 01 keeps status", stat_o, 8'h01);
    step(8'h00, 1'b0, 1'b1);

    cur_req = "R7";
    wr_cfg(2'b00, 1'b0);
    step(8'h01);
    chk("R7", "pulse cycle 1", irq_no, 0);
    for (int k = 2; k <= PL; k++) begin
      step();
      chk("R7", "pulse held", irq_no, 0);
    end
    step();
    chk("R7", "pulse ends after PULSE_LEN", irq_no, 1);
    step(8'h20); step(); step(8'h80);
    for (int k = 1; k < PL; k++) begin
      step();
      chk("R7", "restarted pulse held", irq_no, 0);
    end
    step();
    chk("R7", "restarted pulse ends", irq_no, 1);
    step(8'h02);
    chk("R7", "masked event no pulse", irq_no, 1);

    cur_req = "R2";
    wr_cfg(2'b11, 1'b0);
    chk("R2", "mode 11 acts as level", irq_no, 0);
    step(8'h00, 1'b1);
    chk("R2", "mode 11 read keeps status", stat_o, 8'hA1);
    step(8'h00, 1'b0, 1'b1);
    chk("R2", "mode 11 sw clear", irq_no, 1);

    cur_req = "mixed R3 R4 R7 R8 R9";
    for (int c = 0; c < 600; c++) begin
      logic [N-1:0] ev;
      ev = N'($urandom & $urandom & $urandom);
      mask_we_i = ($urandom_range(0, 19) == 0);
      mask_wdata_i = N'($urandom);
      cfg_we_i = ($urandom_range(0, 24) == 0);
      cfg_mode_i = 2'($urandom);
      cfg_enh_i = 1'($urandom);
      step(ev, ($urandom_range(0, 3) == 0), ($urandom_range(0, 19) == 0));
      mask_we_i = 1'b0; cfg_we_i = 1'b0;
    end

    @(negedge clk_i); #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule